// File: doc/BRIEF.md
# Asynchronous SRAM Read Strobe Sequencer

This block runs the read side of an asynchronous static RAM from one interface clock. A read request with an address sets off a fixed two-state sequence. In the first state the block drives the active-low chip-enable and output-enable strobes low together and puts the registered address on the memory pins. It samples the memory data bus on the clock edge that leaves that state, and it releases both strobes in the second state. The write-enable strobe is never driven low.

One cycle after the second state, the block presents the captured word to a downstream FIFO-style write port with a single-cycle valid pulse. Each state lasts one clock period. The chip-enable-to-data and output-enable-to-data access times both fit inside one period, so one state is enough for the access. A new read can be accepted during the second state, which lets reads run back to back with no idle cycle between them. If the downstream port is not ready when the word is offered, the word is lost and a sticky overflow flag is raised.

Top module: `sramRdSeq`

## Requirements
- R1: While `rstN` is low at a clock edge, the block goes idle after that edge. In idle, `memCeN`, `memOeN` and `memWeN` are 1, `busy` is 0, `wrValid` is 0, `overflow` is 0 and `memAddr` is 0.
- R2: When a request is accepted, `memCeN` and `memOeN` are both 0 for exactly the one following cycle (the access state). They are 1 in every other cycle.
- R3: `memWeN` is 1 in every cycle after reset.
- R4: `memAddr` takes the value of `reqAddr` at the accepting edge. It stays unchanged through the access state and the capture state, and it holds its value while the block is idle.
- R5: The word presented on `wrData` is the value that `memData` had at the clock edge ending the access state. Values of `memData` at any other edge have no effect.
- R6: `wrValid` is 1 for exactly one cycle: the cycle after the capture state, which is three cycles after the accepting edge. `wrData` holds the captured word in that cycle.
- R7: `busy` is 1 only during the access state. A request made while `busy` is 1 is ignored.
- R8: A request made during the capture state is accepted, so the next access state follows with no idle cycle between the two reads.
- R9: If `wrValid` is 1 and `wrReady` is 0 at a clock edge, `overflow` becomes 1 after that edge. It then stays 1 until reset.
- R10: While `reqValid` is 0, no sequence starts: the strobes stay 1 and `memAddr` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rstN | input | 1 | Synchronous reset, active low |
| reqValid | input | 1 | Read request |
| reqAddr | input | ADDR_W | Address of the requested word |
| busy | output | 1 | High while a new request cannot be accepted |
| memAddr | output | ADDR_W | Address pins of the SRAM |
| memCeN | output | 1 | SRAM chip enable, active low |
| memOeN | output | 1 | SRAM output enable, active low |
| memWeN | output | 1 | SRAM write enable, active low (always high) |
| memData | input | DATA_W | SRAM data bus, read direction |
| wrData | output | DATA_W | Captured word to the downstream port |
| wrValid | output | 1 | One-cycle pulse marking `wrData` valid |
| wrReady | input | 1 | Downstream port can take a word |
| overflow | output | 1 | Sticky flag: a word was offered while not ready |

## Verification
The case that is hardest to reach from the ports is a word offered while `wrReady` is low in the middle of a back-to-back stream. For that, the valid pulse of one read has to fall in the same cycle as the access state of the next read. The bench holds `reqValid` high for long stretches so that reads chain through the capture state. It toggles `wrReady` pseudo-randomly while `memData` changes on every cycle. This shows that only the word present at the edge ending the access state is kept, and that the overflow flag rises on the first dropped word. A mid-sequence reset then confirms that the flag and any pending pulse are cleared.

// File: rtl/sramRdPkg.sv
package sramRdPkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACC  = 2'd1,
    ST_CAP  = 2'd2
  } seqState_t;

  typedef struct packed {
    logic ceN;
    logic oeN;
    logic weN;
    logic loadAddr;
    logic capture;
    logic emit;
  } seqCtl_t;

endpackage

// File: rtl/sramRdCtrl.sv
module sramRdCtrl
  import sramRdPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  output logic    busy,
  output seqCtl_t ctl
);

  seqState_t state, stateNext;
  logic accept;

  assign busy   = (state == ST_ACC);
  assign accept = reqValid && !busy;

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: stateNext = accept ? ST_ACC : ST_IDLE;
      ST_ACC:  stateNext = ST_CAP;
      ST_CAP:  stateNext = accept ? ST_ACC : ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    ctl.ceN      = (state != ST_ACC);
    ctl.oeN      = (state != ST_ACC);
    ctl.weN      = 1'b1;
    ctl.loadAddr = accept;
    ctl.capture  = (state == ST_ACC);
    ctl.emit     = (state == ST_CAP);
  end

  // R2: the enable strobes are low for one cycle only
  assert_strobe_one_cycle_R2: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.ceN |=> ctl.ceN);

  // R3
  assert_we_high_R3: assert property (@(posedge clk) disable iff (!rstN)
    ctl.weN);

  // R7: busy never lasts two cycles
  assert_busy_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !busy);

  // R8: an accepted request always leads straight into the access state
  assert_accept_next_R8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !busy) |=> busy);

endmodule

// File: rtl/sramRdPath.sv
module sramRdPath
  import sramRdPkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCtl_t           ctl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] memData,
  input  logic              wrReady,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] wrData,
  output logic              wrValid,
  output logic              overflow
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] capQ;
  logic [DATA_W-1:0] outQ;
  logic              validQ;
  logic              ovfQ;

  always_ff @(posedge clk) begin
    if (!rstN)             addrQ <= '0;
    else if (ctl.loadAddr) addrQ <= reqAddr;
  end

  always_ff @(posedge clk) begin
    if (!rstN)            capQ <= '0;
    else if (ctl.capture) capQ <= memData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outQ   <= '0;
      validQ <= 1'b0;
    end else begin
      validQ <= ctl.emit;
      if (ctl.emit) outQ <= capQ;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                    ovfQ <= 1'b0;
    else if (validQ && !wrReady)  ovfQ <= 1'b1;
  end

  assign memAddr  = addrQ;
  assign wrData   = outQ;
  assign wrValid  = validQ;
  assign overflow = ovfQ;

  // R4: address steady from the access state into the capture state
  assert_addr_stable_R4: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.ceN |=> $stable(memAddr));

  // R6: valid is a pulse
  assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |=> !wrValid);

  // R9: a dropped word raises the flag, which then stays up
  assert_ovf_set_R9: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !wrReady) |=> overflow);
  assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow);

endmodule

// File: rtl/sramRdSeq.sv
module sramRdSeq
  import sramRdPkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              busy,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memOeN,
  output logic              memWeN,
  input  logic [DATA_W-1:0] memData,
  output logic [DATA_W-1:0] wrData,
  output logic              wrValid,
  input  logic              wrReady,
  output logic              overflow
);

  seqCtl_t ctl;

  sramRdCtrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .busy     (busy),
    .ctl      (ctl)
  );

  sramRdPath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .reqAddr  (reqAddr),
    .memData  (memData),
    .wrReady  (wrReady),
    .memAddr  (memAddr),
    .wrData   (wrData),
    .wrValid  (wrValid),
    .overflow (overflow)
  );

  assign memCeN = ctl.ceN;
  assign memOeN = ctl.oeN;
  assign memWeN = ctl.weN;

  // R2: both enables move together at the pins
  assert_ce_oe_pair_R2: assert property (@(posedge clk) disable iff (!rstN)
    (memCeN == memOeN));

endmodule

// File: tb/sramRdSeq_test.sv
module sramRdSeq_test;
  localparam int AW = 12;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] memData = '0;
  logic          wrReady = 1'b1;
  logic          busy, memCeN, memOeN, memWeN, wrValid, overflow;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] wrData;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  sramRdSeq #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .busy(busy), .memAddr(memAddr), .memCeN(memCeN), .memOeN(memOeN),
    .memWeN(memWeN), .memData(memData), .wrData(wrData), .wrValid(wrValid),
    .wrReady(wrReady), .overflow(overflow)
  );

  always #5 clk = ~clk;

  // behavioural reference: phase 0 idle, 1 access, 2 capture
  int phase = 0;
  int addrM = 0, capM = 0, dataM = 0;
  bit validM = 0, ovfM = 0, inReset = 1;

  always @(posedge clk) begin
    if (!rstN) begin
      phase = 0; addrM = 0; validM = 0; ovfM = 0; inReset = 1;
    end else begin
      inReset = 0;
      if (validM && !wrReady) ovfM = 1;
      validM = (phase == 2);
      if (phase == 2) dataM = capM;
      if (phase == 1) begin
        capM = int'(memData);
        phase = 2;
      end else if (reqValid) begin
        addrM = int'(reqAddr);
        phase = 1;
      end else begin
        phase = 0;
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      if (inReset) begin
        check("R1 strobes", {memCeN, memOeN, memWeN}, 7);
        check("R1 busy/valid/ovf", {busy, wrValid, overflow}, 0);
        check("R1 addr", int'(memAddr), 0);
      end else begin
        check("R2 ceN", int'(memCeN), (phase == 1) ? 0 : 1);
        check("R2 oeN", int'(memOeN), (phase == 1) ? 0 : 1);
        check("R3 weN", int'(memWeN), 1);
        check("R4 addr", int'(memAddr), addrM);
        check("R7 busy", int'(busy), (phase == 1) ? 1 : 0);
        check("R6 wrValid", int'(wrValid), int'(validM));
        if (validM) check("R5 wrData", int'(wrData), dataM);
        check("R9 overflow", int'(overflow), int'(ovfM));
      end
    end
  end

  always @(posedge clk) memData <= DW'($urandom);

  task automatic step(input bit rv, input int a, input bit rdy);
    @(posedge clk); #1;
    reqValid = rv; reqAddr = AW'(a); wrReady = rdy;
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) step(0, 0, 1);
    rstN = 1;
    // R10: no request, nothing moves
    repeat (4) step(0, 'h55, 1);
    @(negedge clk);
    check("R10 idle strobes", {memCeN, memOeN}, 3);
    check("R10 idle addr", int'(memAddr), 0);
    // single reads
    for (int i = 0; i < 6; i++) begin
      step(1, 'h100 + i, 1);
      step(0, 0, 1);
      repeat (3) step(0, 0, 1);
    end
    // R8: back-to-back, access state every other cycle
    step(1, 'h3A0, 1);
    step(1, 'h3A1, 1);
    @(negedge clk);
    check("R8 access after accept", int'(busy), 1);
    step(1, 'h3A2, 1);
    @(negedge clk);
    check("R8 capture state not busy", int'(busy), 0);
    step(1, 'h3A3, 1);
    @(negedge clk);
    check("R8 next access without gap", int'(busy), 1);
    repeat (40) step(1, int'($urandom) & 'hFFF, 1);
    // random mix with ready high
    for (int i = 0; i < 400; i++) step(($urandom % 3) != 0, int'($urandom) & 'hFFF, 1);
    // ready dropping: overflow appears and sticks
    for (int i = 0; i < 400; i++) step(($urandom % 2) != 0, int'($urandom) & 'hFFF, ($urandom % 4) != 0);
    // reset in the middle of a sequence
    step(1, 'h777, 1);
    step(0, 0, 1);
    rstN = 0;
    step(0, 0, 1);
    step(0, 0, 1);
    rstN = 1;
    for (int i = 0; i < 300; i++) step(($urandom % 2) != 0, int'($urandom) & 'hFFF, ($urandom % 5) != 0);
    repeat (5) step(0, 0, 1);
    @(negedge clk);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule